// File: doc/BRIEF.md
# Instruction-Address Profiling Window

This block turns the instruction stream of one chosen processor into a measurement window for on-chip profiling counters. It watches the execute-stage program counter together with its valid qualifier and compares it against two instruction addresses that are fixed when the chip is built. When the opening address executes, the `running` output goes high and stays high. When the closing address executes, `running` goes low again. Activity counters elsewhere in the chip are gated by `running`.

Software never has to write a register to start or stop a measurement. Only the addresses of two chosen instructions are needed, so the program under test runs exactly as it would without profiling. A one-cycle `done` pulse marks the end of each window, so a reader of the counters knows when the values are final.

The comparators can be retimed. `MATCH_STAGES` inserts register stages between the address compare and the window state. This shortens the path from the program-counter bus in exchange for added latency.

Top module: `pcwin_gate`

## Requirements
- R1: While reset is held and after it is released, `running` and `done` are low, and `running` stays low until the first valid start match.
- R2: A cycle where `pc_ex_vld` is 1 and `pc_ex` equals `START_ADDR` (and not `STOP_ADDR`) sets `running` high 1+`MATCH_STAGES` clock edges later (one edge with the default of 0).
- R3: A cycle where `pc_ex_vld` is 1 and `pc_ex` equals `STOP_ADDR` drives `running` low 1+`MATCH_STAGES` edges later.
- R4: Matching is a full `PC_W`-bit equality: a PC that differs from either address in any single bit, the lowest or the highest included, neither opens nor closes the window.
- R5: A PC presented with `pc_ex_vld` at 0 is ignored, even when it equals the start or stop address.
- R6: A start match while `running` is high leaves it high with no `done`, and a stop match while `running` is low leaves it low with no `done`.
- R7: When `START_ADDR` equals `STOP_ADDR`, the stop match takes priority: `running` never rises and `done` never pulses.
- R8: `done` is high for exactly one cycle: the first cycle in which `running` is low after a stop match closed an open window. `done` is never high otherwise, including when reset clears an open window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the processor being observed |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_ex | input | PC_W | Program counter of the instruction in the execute stage |
| pc_ex_vld | input | 1 | High when `pc_ex` holds a real executing instruction |
| running | output | 1 | High while the profiling window is open |
| done | output | 1 | One-cycle pulse in the first cycle after a window closes |

## Verification
The PC stream mixes exact start and stop addresses, the same addresses with the valid qualifier low, and near-miss addresses that differ only in bit 0 or bit 31. Together these separate a true full-width compare from a compare that drops edge bits or ignores the qualifier. Start and stop matches are each repeated in the state where they should do nothing. Windows of several lengths, down to one cycle, show whether `done` follows the falling edge of `running` exactly. A second instance, built with equal start and stop addresses, shows which match wins when both fire. A reset taken in the middle of an open window confirms that `done` stays low.

// File: rtl/pcwin_pkg.sv
`timescale 1ns/1ps
package pcwin_pkg;
   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   localparam int HIT_START = 0;
   localparam int HIT_STOP  = 1;
   localparam int N_HITS    = 2;
endpackage

// File: rtl/pcwin_addr_match.sv
`timescale 1ns/1ps
module pcwin_addr_match #(
   parameter int              PC_W         = 32,
   parameter logic [PC_W-1:0] ADDR         = '0,
   parameter int              MATCH_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pc,
   input  logic            pc_vld,
   output logic            hit
);
   logic eq;
   assign eq = pc_vld && (pc == ADDR);

   if (MATCH_STAGES == 0) begin : g_comb
      assign hit = eq;
   end else begin : g_piped
      logic [MATCH_STAGES:0] pipe;
      assign pipe[0] = eq;
      for (genvar s = 0; s < MATCH_STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s+1] <= 1'b0;
            else        pipe[s+1] <= pipe[s];
         end
      end
      assign hit = pipe[MATCH_STAGES];
   end
endmodule

// File: rtl/pcwin_ctrl.sv
`timescale 1ns/1ps
module pcwin_ctrl
   import pcwin_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit_start,
   input  logic hit_stop,
   output logic running,
   output logic done
);
   win_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WIN_IDLE: if (hit_start && !hit_stop) state_d = WIN_OPEN;
         WIN_OPEN: if (hit_stop)               state_d = WIN_IDLE;
         default:                              state_d = WIN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WIN_IDLE;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= (state_q == WIN_OPEN) && (state_d == WIN_IDLE);
      end
   end

   assign running = (state_q == WIN_OPEN);
endmodule

// File: rtl/pcwin_gate.sv
`timescale 1ns/1ps
module pcwin_gate
   import pcwin_pkg::*;
#(
   parameter int              PC_W         = 32,
   parameter logic [PC_W-1:0] START_ADDR   = 'h0000_1040,
   parameter logic [PC_W-1:0] STOP_ADDR    = 'h0000_10A8,
   parameter int              MATCH_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pc_ex,
   input  logic            pc_ex_vld,
   output logic            running,
   output logic            done
);
   localparam logic [N_HITS*PC_W-1:0] CMP_ADDRS = {STOP_ADDR, START_ADDR};

   if (PC_W < 8 || PC_W > 64) begin : g_bad_width
      $error("pcwin_gate: PC_W must lie in 8..64");
   end
   if (MATCH_STAGES < 0 || MATCH_STAGES > 4) begin : g_bad_stages
      $error("pcwin_gate: MATCH_STAGES must lie in 0..4");
   end

   logic [N_HITS-1:0] hits;
   logic              hit_start;
   logic              hit_stop;

   for (genvar g = 0; g < N_HITS; g++) begin : g_cmp
      pcwin_addr_match #(
         .PC_W        (PC_W),
         .ADDR        (CMP_ADDRS[g*PC_W +: PC_W]),
         .MATCH_STAGES(MATCH_STAGES)
      ) i_match (
         .clk   (clk),
         .rst_n (rst_n),
         .pc    (pc_ex),
         .pc_vld(pc_ex_vld),
         .hit   (hits[g])
      );
   end

   assign hit_start = hits[HIT_START];
   assign hit_stop  = hits[HIT_STOP];

   pcwin_ctrl i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_start(hit_start),
      .hit_stop (hit_stop),
      .running  (running),
      .done     (done)
   );
endmodule

// File: rtl/pcwin_gate_chk.sv
`timescale 1ns/1ps
module pcwin_gate_chk (
   input logic clk,
   input logic rst_n,
   input logic hit_start,
   input logic hit_stop,
   input logic running,
   input logic done
);
   // R2
   start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_start && !hit_stop |=> running);

   // R3 R7
   stop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_stop |=> !running);

   // R6
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_start && !hit_stop |=> $stable(running));

   // R8
   done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> done);

   // R8
   done_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !running && $past(running));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind pcwin_gate pcwin_gate_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hit_start(hit_start),
   .hit_stop (hit_stop),
   .running  (running),
   .done     (done)
);

// File: tb/test_pcwin_gate.sv
`timescale 1ns/1ps
module test_pcwin_gate;
   localparam logic [31:0] A_START = 32'h0000_1040;
   localparam logic [31:0] A_STOP  = 32'h0000_10A8;
   localparam logic [31:0] A_SAME  = 32'h0000_2000;

   typedef struct {
      logic  run;
      logic  dn;
      logic  run2;
      logic  dn2;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc = '0;
   logic        vld = 1'b0;
   logic        running, done, running2, done2;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   exp_t sb[$];
   logic m_run = 1'b0;
   logic m_run2 = 1'b0;

   always #2 clk = ~clk;

   pcwin_gate #(.PC_W(32), .START_ADDR(A_START), .STOP_ADDR(A_STOP)) i_pcwin_gate (
      .clk(clk), .rst_n(rst_n), .pc_ex(pc), .pc_ex_vld(vld),
      .running(running), .done(done));

   pcwin_gate #(.PC_W(32), .START_ADDR(A_SAME), .STOP_ADDR(A_SAME)) i_pcwin_gate_same (
      .clk(clk), .rst_n(rst_n), .pc_ex(pc), .pc_ex_vld(vld),
      .running(running2), .done(done2));

   task automatic finish_sim();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic check_now(string tag, logic r, logic d, logic r2, logic d2);
      checks++;
      if (running !== r || done !== d || running2 !== r2 || done2 !== d2) begin
         errors++;
         $display("FAIL %s: got run=%b done=%b run2=%b done2=%b expected run=%b done=%b run2=%b done2=%b",
                  tag, running, done, running2, done2, r, d, r2, d2);
      end
   endtask

   // Driver: applies one PC cycle and pushes the outputs expected after the next edge.
   task automatic step(logic [31:0] p, logic v, string tag);
      exp_t e;
      logic st, sp, st2, sp2;
      @(negedge clk);
      pc  = p;
      vld = v;
      st  = v && (p == A_START);
      sp  = v && (p == A_STOP);
      st2 = v && (p == A_SAME);
      sp2 = v && (p == A_SAME);
      e.dn  = m_run && sp;
      e.dn2 = m_run2 && sp2;
      m_run  = sp  ? 1'b0 : (st  ? 1'b1 : m_run);
      m_run2 = sp2 ? 1'b0 : (st2 ? 1'b1 : m_run2);
      e.run  = m_run;
      e.run2 = m_run2;
      e.tag  = tag;
      @(posedge clk);
      sb.push_back(e);
   endtask

   // Monitor: compares outputs with the scoreboard away from the active edge.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check_now(e.tag, e.run, e.dn, e.run2, e.dn2);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_sim();
   end

   initial begin
      repeat (3) @(negedge clk);
      check_now("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      step(32'h0000_0100, 1'b1, "R1 no start yet");
      step(A_START, 1'b0, "R5 start without valid");
      step(A_STOP, 1'b1, "R6 stop while idle");
      step(A_START ^ 32'h1, 1'b1, "R4 start bit0 miss");
      step(A_START ^ 32'h8000_0000, 1'b1, "R4 start bit31 miss");
      step(A_START, 1'b1, "R2 valid start");
      step(32'h0000_1044, 1'b1, "R2 held open");
      step(A_START, 1'b1, "R6 start while open");
      step(A_STOP, 1'b0, "R5 stop without valid");
      step(A_STOP ^ 32'h1, 1'b1, "R4 stop bit0 miss");
      step(A_STOP ^ 32'h8000_0000, 1'b1, "R4 stop bit31 miss");
      step(A_STOP, 1'b1, "R3 valid stop");
      step(32'h0000_10AC, 1'b1, "R8 done ends");
      step(A_SAME, 1'b1, "R7 same address stop wins");
      step(A_SAME, 1'b1, "R7 same address again");
      step(32'h0, 1'b0, "R7 idle after");
      for (int k = 0; k < 5; k++) begin
         step(A_START, 1'b1, "R2 window open");
         for (int j = 0; j < k; j++) step(32'h0000_1050 + j, (j % 2) == 0, "R6 window body");
         step(A_STOP, 1'b1, "R3 window close");
         step(32'h0000_3000, 1'b1, "R8 pulse length");
      end
      step(A_START, 1'b1, "R2 open before reset");
      step(32'h0000_1048, 1'b1, "R2 open before reset");
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_now("R8 reset clears window", 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check_now("R8 no done on reset", 1'b0, 1'b0, 1'b0, 1'b0);
      m_run  = 1'b0;
      m_run2 = 1'b0;
      rst_n = 1'b1;
      step(A_STOP, 1'b1, "R1 stop after reset");
      step(32'h0000_0200, 1'b1, "R1 stays low");
      @(negedge clk);
      @(negedge clk);
      finish_sim();
   end
endmodule